// File: doc/BRIEF.md
# Fan Tachometer and Speed Regulator

This block measures how fast a fan turns and computes the 8-bit drive level for it. The tachometer input is first synchronised and filtered against glitches. The block then counts reference ticks over four consecutive intervals between tach transitions, which is one revolution of a two-pole fan. The tick count is doubled, clipped to 13 bits and reported left-justified in a 16-bit reading. When the counter saturates before the window closes, the fan is treated as stopped: the reading takes the sentinel 0xFFF8 and a stall flag is raised.

The drive level has two sources. In direct mode the value software writes to the setting register goes straight to the drive output. In speed mode a regulator moves the setting one step per update interval, which steers the measured count toward a programmed target count. Counts inside a dead-band around the target cause no step. A target whose upper byte is all ones switches the fan off. When the fan leaves the off state, it is started at full drive. A start that never yields a valid reading sets a spin-up failure flag. A fan that stays too slow at full drive sets a drive failure flag.

Software reaches the configuration, setting, target, reading and status through a word-wide register port. Status bits are cleared by writing 1 to them.

Top module: `fan_speed_ctl`

## Requirements
- R1: After reset the reading and the target both read 0xFFF8, configuration, setting and status read 0, and the drive output is 0.
- R2: The tach input passes through two synchroniser flops and then a filter that accepts a new level only after FILT_LEN consecutive equal samples. A pulse shorter than FILT_LEN clock cycles produces no edge.
- R3: Every transition of the filtered tach, rising or falling, is an edge. The reading becomes min(2 × T, 0x1FFF) shifted left by 3, where T is the number of cycles with ref_tick high from the first edge of a window to the fifth. The fifth edge opens the next window.
- R4: When the doubled tick count reaches 0x1FFF before a window completes, the reading becomes 0xFFF8 and status bit 0 (stall) is set. A reading whose upper byte is 0xFF is invalid.
- R5: With configuration bit 7 clear (direct mode), drive_o equals the setting register at address 1, and the target has no effect on the drive.
- R6: The status register at address 4 holds stall (bit 0), spin-up failure (bit 1) and drive failure (bit 5). Writing 1 to a bit clears it and writing 0 leaves it unchanged. A new event in the same cycle as the clear wins.
- R7: With configuration bit 7 set (speed mode), an update occurs every BASE_TICKS << cfg[2:0] reference ticks. At each update the setting rises by 1 when count > target + DEADBAND or the reading is invalid, and falls by 1 when count + DEADBAND < target. Otherwise it holds. The setting saturates at 0 and 255.
- R8: In speed mode, a target whose bits 15:8 are all ones forces drive_o to 0. The setting register keeps its value, and no updates occur.
- R9: When speed mode becomes active (speed mode with a target that is not off), the setting jumps to 255 and holds until a valid reading appears. If SPIN_LIMIT updates pass without one, status bit 1 is set.
- R10: An update outside spin-up that finds the setting at 255 while the fan is still too slow sets status bit 5.
- R11: Register map: address 0 holds configuration bits 7 and 2:0 (other bits read 0), address 1 the setting, address 2 the target (bits 2:0 read 0), address 3 the reading, and address 4 the status. Writes to address 3 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe from the measurement reference clock |
| tach_in | input | 1 | Asynchronous tachometer signal from the fan |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data, combinational from reg_addr |
| drive_o | output | 8 | Drive setting for the downstream PWM stage |

## Verification
Register writes take effect at the clock edge that samples reg_wr, and read data is combinational. The bench therefore reads one time step after a negative edge. A reading settles one cycle after the fifth filtered edge, but the synchroniser and filter add a fixed delay that makes the exact edge awkward to predict. The bench waits long enough for at least one whole window under the current tach period before it compares the reading. A stall appears 4096 ticks after the last restart, so the bench samples after 4300 cycles and clears the flag well before the next stall is due. The regulator steps once every four ticks and its phase is not tied to the write, so step counts are checked against a window of plus or minus a few steps, while hold and saturation are checked exactly.

// File: rtl/fan_ctl_pkg.sv
// Package: shared constants, register selectors and helper functions for
// the fan speed controller. Assumes a 13-bit count in a 16-bit word.
package fan_ctl_pkg;

    localparam int CNT_W  = 13;
    localparam int WORD_W = 16;
    localparam int LJ_SH  = WORD_W - CNT_W;
    localparam logic [CNT_W-1:0]  CNT_MAX  = {CNT_W{1'b1}};
    localparam logic [WORD_W-1:0] WORD_OFF = {CNT_MAX, {LJ_SH{1'b0}}};

    typedef enum logic [2:0] {
        SEL_CFG  = 3'd0,
        SEL_SET  = 3'd1,
        SEL_TGT  = 3'd2,
        SEL_READ = 3'd3,
        SEL_STS  = 3'd4
    } reg_sel_e;

    // Upper byte all ones marks a stopped fan or an off command.
    function automatic logic cnt_is_sentinel(input logic [CNT_W-1:0] c);
        return &c[CNT_W-1:CNT_W-8];
    endfunction

endpackage

// File: rtl/fan_tach_filter.sv
// Tach front end: two-flop synchroniser, then a level filter that accepts a
// new level only after FILT_LEN equal samples. Emits a one-cycle pulse on
// every accepted transition. Assumes FILT_LEN >= 2.
module fan_tach_filter #(
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tach_i,
    output logic edge_o
);

    logic [1:0]          sync_q;
    logic [FILT_LEN-1:0] hist_q;
    logic                filt_q;
    logic                edge_q;
    logic                all_hi;
    logic                all_lo;

    assign all_hi = &hist_q;
    assign all_lo = ~|hist_q;

    // Synchronise the asynchronous input and shift it into the history.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '0;
            hist_q <= '0;
        end else begin
            sync_q <= {sync_q[0], tach_i};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
        end
    end

    // Accept a new filtered level and flag the transition.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            filt_q <= 1'b0;
            edge_q <= 1'b0;
        end else if (all_hi && !filt_q) begin
            filt_q <= 1'b1;
            edge_q <= 1'b1;
        end else if (all_lo && filt_q) begin
            filt_q <= 1'b0;
            edge_q <= 1'b1;
        end else begin
            edge_q <= 1'b0;
        end
    end

    assign edge_o = edge_q;

    // R2: a filtered transition only follows a history that had settled there.
    a_r2_filter_settled: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> $past(hist_q[FILT_LEN-1]) == filt_q);

endmodule

// File: rtl/fan_tach_meter.sv
// Tach period meter: counts reference ticks times MULT over EDGES filtered
// edges and reports a left-justified, saturating count. A count reaching
// the maximum before the window closes is a stall. Assumes EDGES >= 2.
module fan_tach_meter
    import fan_ctl_pkg::*;
#(
    parameter int EDGES = 5,
    parameter int MULT  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ref_tick,
    input  logic               edge_i,
    output logic [WORD_W-1:0]  reading_o,
    output logic               valid_o,
    output logic               stall_o
);

    localparam int EW = $clog2(EDGES + 1);
    localparam logic [CNT_W:0] MULT_W  = (CNT_W+1)'(MULT);
    localparam logic [EW-1:0]  LAST_ED = EW'(EDGES - 1);

    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cnt_nx;
    logic [CNT_W:0]    cnt_sum;
    logic [EW-1:0]     edges_q;
    logic [WORD_W-1:0] reading_q;
    logic              stall_q;

    // Next tick count including this cycle's tick, clipped at the maximum.
    always_comb begin
        cnt_sum = {1'b0, cnt_q} + MULT_W;
        if (!ref_tick)
            cnt_nx = cnt_q;
        else if (cnt_sum >= {1'b0, CNT_MAX})
            cnt_nx = CNT_MAX;
        else
            cnt_nx = cnt_sum[CNT_W-1:0];
    end

    // Window sequencing: start, count edges, capture, or declare a stall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            edges_q   <= '0;
            reading_q <= WORD_OFF;
            stall_q   <= 1'b0;
        end else begin
            stall_q <= 1'b0;
            if (cnt_nx == CNT_MAX) begin
                stall_q   <= 1'b1;
                reading_q <= WORD_OFF;
                cnt_q     <= '0;
                edges_q   <= '0;
            end else if (edge_i) begin
                if (edges_q == LAST_ED) begin
                    reading_q <= {cnt_nx, {LJ_SH{1'b0}}};
                    edges_q   <= EW'(1);
                    cnt_q     <= '0;
                end else if (edges_q == '0) begin
                    edges_q <= EW'(1);
                    cnt_q   <= '0;
                end else begin
                    edges_q <= edges_q + EW'(1);
                    cnt_q   <= cnt_nx;
                end
            end else begin
                cnt_q <= cnt_nx;
            end
        end
    end

    assign reading_o = reading_q;
    assign valid_o   = !cnt_is_sentinel(reading_q[WORD_W-1:LJ_SH]);
    assign stall_o   = stall_q;

endmodule

// File: rtl/fan_speed_loop.sv
// Drive regulator: holds the 8-bit setting, steps it toward the target
// count once per update interval in speed mode, runs spin-up at full
// drive, and pulses the spin-up and drive failure events.
module fan_speed_loop
    import fan_ctl_pkg::*;
#(
    parameter int BASE_TICKS = 1638,
    parameter int DEADBAND   = 16,
    parameter int SPIN_LIMIT = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_tick,
    input  logic             loop_en,
    input  logic [2:0]       interval_sel,
    input  logic [CNT_W-1:0] target_cnt,
    input  logic [CNT_W-1:0] meas_cnt,
    input  logic             meas_valid,
    input  logic             set_wr,
    input  logic [7:0]       set_data,
    output logic [7:0]       setting_o,
    output logic [7:0]       drive_o,
    output logic             spin_fail_o,
    output logic             drive_fail_o
);

    localparam int IW = $clog2(BASE_TICKS * 128 + 1);
    localparam int SW = $clog2(SPIN_LIMIT + 1);
    localparam logic [CNT_W:0] DB_W = (CNT_W+1)'(DEADBAND);

    logic [IW-1:0] int_cnt_q;
    logic [IW-1:0] int_lim;
    logic          upd;
    logic          target_off;
    logic          active;
    logic          active_q;
    logic          spin_start;
    logic          spin_q;
    logic [SW-1:0] spin_cnt_q;
    logic [7:0]    setting_q;
    logic          too_slow;
    logic          too_fast;
    logic          spin_fail_q;
    logic          drive_fail_q;

    assign int_lim    = IW'(BASE_TICKS) << interval_sel;
    assign upd        = ref_tick && ((int_cnt_q + IW'(1)) >= int_lim);
    assign target_off = cnt_is_sentinel(target_cnt);
    assign active     = loop_en && !target_off;
    assign spin_start = active && !active_q;
    assign too_slow   = !meas_valid || ({1'b0, meas_cnt} > ({1'b0, target_cnt} + DB_W));
    assign too_fast   = meas_valid && (({1'b0, meas_cnt} + DB_W) < {1'b0, target_cnt});

    // Update-interval timer counting reference ticks.
    always_ff @(posedge clk) begin
        if (!rst_n)
            int_cnt_q <= '0;
        else if (upd)
            int_cnt_q <= '0;
        else if (ref_tick)
            int_cnt_q <= int_cnt_q + IW'(1);
    end

    // Track the active state to detect leaving the off state.
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_q <= 1'b0;
        else
            active_q <= active;
    end

    // Spin-up supervision: full drive until a valid reading or timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spin_q      <= 1'b0;
            spin_cnt_q  <= '0;
            spin_fail_q <= 1'b0;
        end else begin
            spin_fail_q <= 1'b0;
            if (spin_start) begin
                spin_q     <= 1'b1;
                spin_cnt_q <= '0;
            end else if (spin_q) begin
                if (meas_valid || !active) begin
                    spin_q <= 1'b0;
                end else if (upd) begin
                    if (spin_cnt_q + SW'(1) >= SW'(SPIN_LIMIT)) begin
                        spin_q      <= 1'b0;
                        spin_fail_q <= 1'b1;
                    end else begin
                        spin_cnt_q <= spin_cnt_q + SW'(1);
                    end
                end
            end
        end
    end

    // Setting register: software write, spin-up jump, or one regulator step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setting_q <= '0;
        end else if (set_wr) begin
            setting_q <= set_data;
        end else if (spin_start) begin
            setting_q <= 8'hFF;
        end else if (active && upd && !spin_q) begin
            if (too_slow && setting_q != 8'hFF)
                setting_q <= setting_q + 8'd1;
            else if (too_fast && setting_q != 8'h00)
                setting_q <= setting_q - 8'd1;
        end
    end

    // Drive failure: still too slow although the setting is at full drive.
    always_ff @(posedge clk) begin
        if (!rst_n)
            drive_fail_q <= 1'b0;
        else
            drive_fail_q <= active && upd && !spin_q && !spin_start
                            && (setting_q == 8'hFF) && too_slow;
    end

    assign setting_o    = setting_q;
    assign drive_o      = (loop_en && target_off) ? 8'h00 : setting_q;
    assign spin_fail_o  = spin_fail_q;
    assign drive_fail_o = drive_fail_q;

    // R7: without a write or spin-up jump the setting moves at most one step.
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(set_wr) && !$past(spin_start)) |->
        ((setting_q - $past(setting_q)) inside {8'h00, 8'h01, 8'hFF}));

endmodule

// File: rtl/fan_speed_ctl.sv
// Top level: register file around the tach filter, period meter and drive
// regulator. Reads are combinational; writes land on the clock edge.
module fan_speed_ctl
    import fan_ctl_pkg::*;
#(
    parameter int FILT_LEN   = 3,
    parameter int EDGES      = 5,
    parameter int MULT       = 2,
    parameter int BASE_TICKS = 1638,
    parameter int DEADBAND   = 16,
    parameter int SPIN_LIMIT = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        ref_tick,
    input  logic        tach_in,
    input  logic        reg_wr,
    input  logic [2:0]  reg_addr,
    input  logic [15:0] reg_wdata,
    output logic [15:0] reg_rdata,
    output logic [7:0]  drive_o
);

    reg_sel_e          sel;
    logic              tach_edge;
    logic [WORD_W-1:0] reading;
    logic              meas_valid;
    logic              stall_ev;
    logic              spin_ev;
    logic              drvf_ev;
    logic [7:0]        setting;
    logic              cfg_loop_q;
    logic [2:0]        cfg_int_q;
    logic [CNT_W-1:0]  target_q;
    logic [2:0]        sts_q;
    logic [2:0]        sts_set;
    logic [2:0]        sts_clr;
    logic              wr_cfg;
    logic              wr_set;
    logic              wr_tgt;
    logic              wr_sts;

    assign sel    = reg_sel_e'(reg_addr);
    assign wr_cfg = reg_wr && (sel == SEL_CFG);
    assign wr_set = reg_wr && (sel == SEL_SET);
    assign wr_tgt = reg_wr && (sel == SEL_TGT);
    assign wr_sts = reg_wr && (sel == SEL_STS);

    fan_tach_filter #(.FILT_LEN(FILT_LEN)) filt_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tach_i (tach_in),
        .edge_o (tach_edge)
    );

    fan_tach_meter #(.EDGES(EDGES), .MULT(MULT)) meter_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_tick  (ref_tick),
        .edge_i    (tach_edge),
        .reading_o (reading),
        .valid_o   (meas_valid),
        .stall_o   (stall_ev)
    );

    fan_speed_loop #(
        .BASE_TICKS (BASE_TICKS),
        .DEADBAND   (DEADBAND),
        .SPIN_LIMIT (SPIN_LIMIT)
    ) loop_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ref_tick     (ref_tick),
        .loop_en      (cfg_loop_q),
        .interval_sel (cfg_int_q),
        .target_cnt   (target_q),
        .meas_cnt     (reading[WORD_W-1:LJ_SH]),
        .meas_valid   (meas_valid),
        .set_wr       (wr_set),
        .set_data     (reg_wdata[7:0]),
        .setting_o    (setting),
        .drive_o      (drive_o),
        .spin_fail_o  (spin_ev),
        .drive_fail_o (drvf_ev)
    );

    // Configuration and target registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_loop_q <= 1'b0;
            cfg_int_q  <= '0;
            target_q   <= CNT_MAX;
        end else begin
            if (wr_cfg) begin
                cfg_loop_q <= reg_wdata[7];
                cfg_int_q  <= reg_wdata[2:0];
            end
            if (wr_tgt)
                target_q <= reg_wdata[WORD_W-1:LJ_SH];
        end
    end

    // Status flags: events set, write-1 clears, a new event wins.
    assign sts_set = {drvf_ev, spin_ev, stall_ev};
    assign sts_clr = wr_sts ? {reg_wdata[5], reg_wdata[1], reg_wdata[0]} : 3'b000;

    always_ff @(posedge clk) begin
        if (!rst_n)
            sts_q <= '0;
        else
            sts_q <= (sts_q & ~sts_clr) | sts_set;
    end

    // Read multiplexer.
    always_comb begin
        case (sel)
            SEL_CFG:  reg_rdata = {8'h00, cfg_loop_q, 4'h0, cfg_int_q};
            SEL_SET:  reg_rdata = {8'h00, setting};
            SEL_TGT:  reg_rdata = {target_q, {LJ_SH{1'b0}}};
            SEL_READ: reg_rdata = reading;
            SEL_STS:  reg_rdata = {10'h000, sts_q[2], 3'b000, sts_q[1], sts_q[0]};
            default:  reg_rdata = '0;
        endcase
    end

    // R4: a newly raised stall flag is always paired with the stopped reading.
    a_r4_stall_reads_off: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[0]) |-> reading == WORD_OFF);

    // R6: writing 1 to the stall bit clears it unless a stall arrives at once.
    a_r6_w1c_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_sts && reg_wdata[0] && !stall_ev) |-> !sts_q[0]);

    // R10: a drive failure is only raised while the drive was at full scale.
    a_r10_drvfail_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_q[2]) |-> $past(drive_o) == 8'hFF);

endmodule

// File: tb/fan_speed_ctl_tb.sv
`timescale 1ns/1ps
module fan_speed_ctl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_tick = 1'b1;
    logic        tach_bg = 1'b0;
    logic        glitch = 1'b0;
    logic        tach_in;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic [7:0]  drive_o;

    int half_per  = 0;
    bit tick_half = 1'b0;
    int n_chk     = 0;
    int n_fail    = 0;
    bit done      = 1'b0;

    assign tach_in = tach_bg ^ glitch;

    always #2.5 clk = ~clk;

    fan_speed_ctl #(
        .FILT_LEN(3), .EDGES(5), .MULT(2),
        .BASE_TICKS(4), .DEADBAND(8), .SPIN_LIMIT(3)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .tach_in(tach_in),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .drive_o(drive_o)
    );

    // Reference tick: every cycle, or every other cycle when halved.
    always @(negedge clk) ref_tick <= tick_half ? ~ref_tick : 1'b1;

    // Background tach toggling with a half period of half_per cycles.
    always begin
        if (half_per == 0) begin
            @(negedge clk);
        end else begin
            repeat (half_per) @(negedge clk);
            tach_bg <= ~tach_bg;
        end
    end

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
        end
    endtask

    task automatic chk_range(input string req, input int act, input int lo, input int hi);
        n_chk++;
        if (act < lo || act > hi) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic do_reset();
        half_per = 0; tick_half = 1'b0; glitch = 1'b0; tach_bg = 1'b0;
        reg_wr = 1'b0;
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // R1: reset values at every address and on the drive output.
    task automatic t_reset();
        logic [15:0] d;
        do_reset();
        rd(3'd3, d); chk("R1 reading", d, 16'hFFF8);
        rd(3'd2, d); chk("R1 target", d, 16'hFFF8);
        rd(3'd0, d); chk("R1 config", d, 16'h0000);
        rd(3'd1, d); chk("R1 setting", d, 16'h0000);
        rd(3'd4, d); chk("R1 status", d, 16'h0000);
        chk("R1 drive", {8'h00, drive_o}, 16'h0000);
    endtask

    // R11 register map and R5 direct drive.
    task automatic t_regs();
        logic [15:0] d;
        do_reset();
        wr(3'd0, 16'h007F);
        rd(3'd0, d); chk("R11 config unused bits", d, 16'h0007);
        wr(3'd2, 16'h1237);
        rd(3'd2, d); chk("R11 target low bits", d, 16'h1230);
        wr(3'd0, 16'h0000);
        wr(3'd1, 16'h005A);
        @(negedge clk);
        chk("R5 direct drive", {8'h00, drive_o}, 16'h005A);
        wr(3'd2, 16'hFFF8);
        @(negedge clk);
        chk("R5 target ignored in direct", {8'h00, drive_o}, 16'h005A);
        wr(3'd3, 16'h1234);
        rd(3'd3, d); chk("R11 reading read-only", d, 16'hFFF8);
    endtask

    // R3: reading under several tach periods and tick rates.
    task automatic t_measure();
        logic [15:0] d;
        do_reset();
        half_per = 50;
        wait_cyc(700);
        rd(3'd3, d); chk("R3 period 50", d, 16'd400 << 3);
        half_per = 100;
        wait_cyc(1300);
        rd(3'd3, d); chk("R3 period 100", d, 16'd800 << 3);
        tick_half = 1'b1;
        wait_cyc(1300);
        rd(3'd3, d); chk("R3 half tick rate", d, 16'd400 << 3);
        half_per = 0;
        tick_half = 1'b0;
    endtask

    // R4 stall and R6 write-1-to-clear.
    task automatic t_stall();
        logic [15:0] d;
        do_reset();
        wait_cyc(4300);
        rd(3'd3, d); chk("R4 stalled reading", d, 16'hFFF8);
        rd(3'd4, d); chk("R4 stall flag", d, 16'h0001);
        wr(3'd4, 16'h0022);
        rd(3'd4, d); chk("R6 other bits no effect", d, 16'h0001);
        wr(3'd4, 16'h0001);
        rd(3'd4, d); chk("R6 stall cleared", d, 16'h0000);
    endtask

    // R2: two-cycle pulses never reach the meter.
    task automatic t_glitch();
        logic [15:0] d;
        do_reset();
        for (int i = 0; i < 20; i++) begin
            @(negedge clk); glitch = 1'b1;
            wait_cyc(2);    glitch = 1'b0;
            wait_cyc(48);
        end
        rd(3'd3, d); chk("R2 glitches rejected", d, 16'hFFF8);
    endtask

    // R8 off target, R9 spin-up failure, R10 drive failure.
    task automatic t_spin_fail();
        logic [15:0] d;
        do_reset();
        wr(3'd0, 16'h0080);
        wr(3'd1, 16'h0040);
        wait_cyc(2);
        chk("R8 off target forces zero", {8'h00, drive_o}, 16'h0000);
        rd(3'd1, d); chk("R8 setting kept", d, 16'h0040);
        wr(3'd2, 16'h0C80);
        wait_cyc(2);
        chk("R9 spin-up full drive", {8'h00, drive_o}, 16'h00FF);
        wait_cyc(60);
        rd(3'd4, d); chk("R9 R10 spin and drive fail", d, 16'h0022);
    endtask

    // R7: regulator direction, dead-band hold, saturation; R10 at full drive.
    task automatic t_loop();
        logic [15:0] d;
        logic [7:0]  s1;
        do_reset();
        half_per = 50;
        wait_cyc(700);
        wr(3'd2, 16'd600 << 3);
        wr(3'd0, 16'h0080);
        wait_cyc(100);
        chk_range("R7 too fast steps down", int'(drive_o), 227, 233);
        wr(3'd2, 16'd404 << 3);
        wait_cyc(8);
        s1 = drive_o;
        wait_cyc(100);
        chk("R7 hold in dead-band", {8'h00, drive_o}, {8'h00, s1});
        wr(3'd2, 16'hFA00);
        wait_cyc(1200);
        chk("R7 saturate low", {8'h00, drive_o}, 16'h0000);
        rd(3'd4, d); chk("R10 no fail while fast", d & 16'h0020, 16'h0000);
        wr(3'd2, 16'd300 << 3);
        wait_cyc(1300);
        chk("R7 saturate high", {8'h00, drive_o}, 16'h00FF);
        rd(3'd4, d); chk("R10 drive fail at full", d & 16'h0020, 16'h0020);
        half_per = 0;
    endtask

    initial begin
        t_reset();
        t_regs();
        t_measure();
        t_stall();
        t_glitch();
        t_spin_fail();
        t_loop();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule